// File: doc/BRIEF.md
# Two-Way Read Cache with Lockable Fill and RAM Mode

This block is the lookup and fill controller of a small two-way set-associative read cache placed in front of a flash memory. The processor issues a word read with an address. A hit returns the stored word on the next cycle. A miss fetches the whole four-word line from memory in a single burst and returns the requested word as soon as it arrives. Each set remembers its most recently used way, and on a miss the line is written into the other way.

The data array has a second use as plain read/write RAM. With RAM mode on, flash reads bypass the cache and the whole array is reachable through a generic RAM port. A two-bit size control can also give part of the array to generic memory while the remaining sets stay in cache use.

Two independent locks are provided. The update lock stops line fills but keeps lookups running. The read lock blanks the debug view of cache contents and stays on until reset. RAM mode overrides both locks.

Top module: `lkc_top`

## Requirements
- R1: A read whose full tag matches a valid way of its set gives `cpu_rvalid` with the stored word on the cycle after the request and issues no memory request. `cpu_ready` is high whenever the controller is idle.
- R2: A cacheable miss issues exactly one memory request with `mem_burst`=1 at the line base, which is the address with its two low bits at zero. The four returned words are stored in ascending order. The requested word is returned on the cycle after it arrives, while the controller is still busy. The tag and valid bit are written after the fourth word.
- R3: Each set holds an MRU way. A hit sets MRU to the hitting way, a fill sets MRU to the filled way, and a miss fills the way that is not the MRU. After reset, MRU is way 0.
- R4: With `cfg_upd_lock`=1, a miss is served by one single-word read (`mem_burst`=0) and no line is filled. Hits still return without any memory access.
- R5: With `cfg_enable`=0, every read is a single-word memory read. Tags and valid bits are left untouched, so lines that were resident still hit after the cache is enabled again.
- R6: Asserting `cfg_rd_lock` sets a read lock that only reset clears. While the lock is set and RAM mode is off, every debug read returns zero.
- R7: A debug read returns its result on the cycle after `dbg_req`. `dbg_addr` is {set, way, word}. With `dbg_tag_sel`=0 the result is the data word. With `dbg_tag_sel`=1 the result is bit 31 = valid, bit 30 = MRU way of the set, and the low bits = the tag (address bits above bit 1).
- R8: With `cfg_ram_mode`=1, every processor read is a single-word memory read. The whole data array can be written and read through the generic port (`gram_addr` = {set, way, word}, read data on the next cycle). Both locks have no effect.
- R9: Switching RAM mode on zeroes the data array. Switching it off, or changing `cfg_ram_size`, invalidates every line.
- R10: `cfg_ram_size` selects the number of cache sets: 0 gives all of them, 1 gives half, 2 gives a quarter and 3 gives none. Cache lookups use only the low index bits that remain. Sets at or above that count belong to generic memory. A generic write into a cache set is dropped, and a generic read of a cache set returns zero. Size 3 makes every processor read a single-word memory read.
- R11: After reset no line is valid, the data array is zero, `cpu_ready`=1, `cpu_rvalid`=0, `mem_req`=0 and the read lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Cache lookups enabled |
| cfg_ram_mode | input | 1 | Whole data array used as generic RAM |
| cfg_ram_size | input | 2 | Cache/generic split of the data array |
| cfg_upd_lock | input | 1 | Suppress line fills on miss |
| cfg_rd_lock | input | 1 | Set the sticky debug-read lock |
| cpu_req | input | 1 | Read request, taken while cpu_ready is high |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_ready | output | 1 | Controller idle, able to take a request |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_burst | output | 1 | 1: four-word line burst, 0: single word |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rvalid | input | 1 | Memory read word valid |
| mem_rdata | input | DATA_W | Memory read word |
| gram_req | input | 1 | Generic RAM access |
| gram_we | input | 1 | Generic RAM write |
| gram_addr | input | SET_W+3 | Generic RAM index {set, way, word} |
| gram_wdata | input | DATA_W | Generic RAM write data |
| gram_rdata | output | DATA_W | Generic RAM read data |
| dbg_req | input | 1 | Debug read |
| dbg_tag_sel | input | 1 | 0: data word, 1: tag/valid/MRU word |
| dbg_addr | input | SET_W+3 | Debug index {set, way, word} |
| dbg_rdata | output | DATA_W | Debug read data |

## Verification
The bench builds the block with its default parameters: 16-bit word addresses, 32-bit data and eight sets. With only eight sets, three addresses that differ in tag alone fall into the same set, so a short sequence can expose an eviction decision that depends on whether the preceding hit updated the MRU way. The same eight sets divide cleanly into half and quarter cache regions, so the bench can reach a generic-memory set and a cache set with two fixed indices. The tag is 14 bits wide and fits under the valid and MRU bits of a debug word, so that layout can be checked with a single exact value.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned OFS_W      = 2;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ISSUE,
        CS_FILL,
        CS_PASS
    } lkc_state_e;

    typedef enum logic [1:0] {
        SZ_ALL     = 2'd0,
        SZ_HALF    = 2'd1,
        SZ_QUARTER = 2'd2,
        SZ_NONE    = 2'd3
    } lkc_size_e;

    // Decision latched when a request misses.
    typedef struct packed {
        logic fill;   // 1: line burst, 0: single word
        logic way;    // way that receives the line
    } lkc_miss_t;

    function automatic logic size_has_cache(input logic [1:0] sz);
        return sz != SZ_NONE;
    endfunction

endpackage

// File: rtl/lkc_tag_store.sv
module lkc_tag_store #(
    parameter int SET_W  = 3,
    parameter int TAG_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic              hit_way,
    output logic              victim,
    input  logic              touch,
    input  logic              touch_way,
    input  logic              fill_done,
    input  logic              fill_way,
    input  logic              inval_all,
    input  logic [SET_W-1:0]  dbg_set,
    input  logic              dbg_way,
    output logic [DATA_W-1:0] dbg_info
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q   [SETS][2];
    logic [1:0]       valid_q [SETS];
    logic [SETS-1:0]  mru_q;
    logic [1:0]       match;
    logic             any_valid;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign hit     = |match;
    assign hit_way = match[1];
    assign victim  = ~mru_q[lk_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s][0] <= '0;
                tag_q[s][1] <= '0;
                valid_q[s]  <= '0;
            end
            mru_q <= '0;
        end else begin
            if (touch) mru_q[lk_set] <= touch_way;
            if (fill_done) begin
                tag_q[lk_set][fill_way]   <= lk_tag;
                valid_q[lk_set][fill_way] <= 1'b1;
                mru_q[lk_set]             <= fill_way;
            end
            if (inval_all) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end
        end
    end

    always_comb begin
        dbg_info              = '0;
        dbg_info[DATA_W-1]    = valid_q[dbg_set][dbg_way];
        dbg_info[DATA_W-2]    = mru_q[dbg_set];
        dbg_info[TAG_W-1:0]   = tag_q[dbg_set][dbg_way];
    end

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    p_fill_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_done && !inval_all) |=> valid_q[$past(lk_set)][$past(fill_way)]);

    p_inval_clears_r9: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !any_valid);

    p_fill_sets_mru_r3: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (mru_q[$past(lk_set)] == $past(fill_way)));

endmodule

// File: rtl/lkc_data_store.sv
module lkc_data_store #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              gram_req,
    input  logic              gram_we,
    input  logic              gram_ok,
    input  logic [IDX_W-1:0]  gram_idx,
    input  logic [DATA_W-1:0] gram_wdata,
    output logic [DATA_W-1:0] gram_rdata,
    input  logic              dbg_req,
    input  logic              dbg_tag_sel,
    input  logic              dbg_block,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic [DATA_W-1:0] dbg_info,
    output logic [DATA_W-1:0] dbg_rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (fill_we) mem_q[fill_idx] <= fill_data;
            if (gram_req && gram_we && gram_ok) mem_q[gram_idx] <= gram_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gram_rdata <= '0;
            dbg_rdata  <= '0;
        end else begin
            if (gram_req && !gram_we) gram_rdata <= gram_ok ? mem_q[gram_idx] : '0;
            if (dbg_req) begin
                if (dbg_block)        dbg_rdata <= '0;
                else if (dbg_tag_sel) dbg_rdata <= dbg_info;
                else                  dbg_rdata <= mem_q[dbg_idx];
            end
        end
    end

    p_locked_dbg_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && dbg_block) |=> (dbg_rdata == '0));

    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (mem_q[0] == '0));

endmodule

// File: rtl/lkc_ctrl.sv
module lkc_ctrl
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cacheable,
    input  logic                    upd_lock,
    input  logic [SET_W-1:0]        set_mask,
    input  logic                    cpu_req,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic                    cpu_ready,
    output logic                    cpu_rvalid,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_burst,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [SET_W-1:0]        lk_set,
    output logic [ADDR_W-OFS_W-1:0] lk_tag,
    output logic [OFS_W-1:0]        lk_word,
    input  logic                    hit,
    input  logic                    victim,
    input  logic [DATA_W-1:0]       hit_data,
    output logic                    touch,
    output logic                    fill_we,
    output logic [SET_W+OFS_W:0]    fill_idx,
    output logic                    fill_done,
    output logic                    fill_way
);
    lkc_state_e          state_q;
    logic [ADDR_W-1:0]   addr_q;
    lkc_miss_t           miss_q;
    logic [OFS_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]   cur_addr;
    logic                take;

    assign cur_addr = (state_q == CS_IDLE) ? cpu_addr : addr_q;
    assign lk_set   = cur_addr[SET_W+OFS_W-1:OFS_W] & set_mask;
    assign lk_tag   = cur_addr[ADDR_W-1:OFS_W];
    assign lk_word  = cur_addr[OFS_W-1:0];

    assign take      = (state_q == CS_IDLE) && cpu_req;
    assign touch     = take && cacheable && hit;
    assign cpu_ready = (state_q == CS_IDLE);
    assign mem_req   = (state_q == CS_ISSUE);
    assign mem_burst = (state_q == CS_ISSUE) && miss_q.fill;
    assign mem_addr  = miss_q.fill ? {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : addr_q;
    assign fill_we   = (state_q == CS_FILL) && mem_rvalid;
    assign fill_idx  = {lk_set, miss_q.way, cnt_q};
    assign fill_way  = miss_q.way;
    assign fill_done = fill_we && (cnt_q == OFS_W'(LINE_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CS_IDLE;
            addr_q     <= '0;
            miss_q     <= '0;
            cnt_q      <= '0;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= 1'b0;
            unique case (state_q)
                CS_IDLE: if (take) begin
                    if (touch) begin
                        cpu_rvalid <= 1'b1;
                        cpu_rdata  <= hit_data;
                    end else begin
                        addr_q      <= cpu_addr;
                        miss_q.fill <= cacheable && !upd_lock;
                        miss_q.way  <= victim;
                        cnt_q       <= '0;
                        state_q     <= CS_ISSUE;
                    end
                end
                CS_ISSUE: state_q <= miss_q.fill ? CS_FILL : CS_PASS;
                CS_FILL: if (mem_rvalid) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == addr_q[OFS_W-1:0]) begin
                        cpu_rvalid <= 1'b1;
                        cpu_rdata  <= mem_rdata;
                    end
                    if (fill_done) state_q <= CS_IDLE;
                end
                CS_PASS: if (mem_rvalid) begin
                    cpu_rvalid <= 1'b1;
                    cpu_rdata  <= mem_rdata;
                    state_q    <= CS_IDLE;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    p_issue_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_idle_no_mem_r1: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    p_hit_next_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && cacheable && hit) |=> (cpu_rvalid && cpu_ready));

    p_burst_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_burst |-> (mem_addr[OFS_W-1:0] == '0));

endmodule

// File: rtl/lkc_top.sv
module lkc_top
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_enable,
    input  logic                 cfg_ram_mode,
    input  logic [1:0]           cfg_ram_size,
    input  logic                 cfg_upd_lock,
    input  logic                 cfg_rd_lock,
    input  logic                 cpu_req,
    input  logic [ADDR_W-1:0]    cpu_addr,
    output logic                 cpu_ready,
    output logic                 cpu_rvalid,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 mem_req,
    output logic                 mem_burst,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 gram_req,
    input  logic                 gram_we,
    input  logic [SET_W+2:0]     gram_addr,
    input  logic [DATA_W-1:0]    gram_wdata,
    output logic [DATA_W-1:0]    gram_rdata,
    input  logic                 dbg_req,
    input  logic                 dbg_tag_sel,
    input  logic [SET_W+2:0]     dbg_addr,
    output logic [DATA_W-1:0]    dbg_rdata
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = SET_W + 1 + OFS_W;

    logic             ram_q, rd_lock_q;
    logic [1:0]       size_q;
    logic             enter_ram, inval_all, cacheable, gram_ok, dbg_block;
    logic [SET_W-1:0] set_mask;

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [OFS_W-1:0] lk_word;
    logic             hit, hit_way, victim, touch;
    logic             fill_we, fill_done, fill_way;
    logic [IDX_W-1:0] fill_idx;
    logic [DATA_W-1:0] hit_data, dbg_info;

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_q     <= 1'b0;
            rd_lock_q <= 1'b0;
            size_q    <= SZ_ALL;
        end else begin
            ram_q  <= cfg_ram_mode;
            size_q <= cfg_ram_size;
            if (cfg_rd_lock) rd_lock_q <= 1'b1;
        end
    end

    assign enter_ram = cfg_ram_mode && !ram_q;
    assign inval_all = (!cfg_ram_mode && ram_q) || (cfg_ram_size != size_q);
    assign set_mask  = {SET_W{1'b1}} >> cfg_ram_size;
    assign cacheable = cfg_enable && !cfg_ram_mode && size_has_cache(cfg_ram_size);
    assign gram_ok   = cfg_ram_mode || !size_has_cache(cfg_ram_size)
                       || (gram_addr[IDX_W-1:IDX_W-SET_W] > set_mask);
    assign dbg_block = rd_lock_q && !cfg_ram_mode;

    lkc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cacheable(cacheable), .upd_lock(cfg_upd_lock), .set_mask(set_mask),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_word(lk_word),
        .hit(hit), .victim(victim), .hit_data(hit_data), .touch(touch),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_done(fill_done), .fill_way(fill_way)
    );

    lkc_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tags (
        .clk(clk), .rst(rst),
        .lk_set(lk_set), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way), .victim(victim),
        .touch(touch), .touch_way(hit_way),
        .fill_done(fill_done), .fill_way(fill_way), .inval_all(inval_all),
        .dbg_set(dbg_addr[IDX_W-1:IDX_W-SET_W]), .dbg_way(dbg_addr[OFS_W]),
        .dbg_info(dbg_info)
    );

    lkc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rst(rst), .clear(enter_ram),
        .rd_idx({lk_set, hit_way, lk_word}), .rd_data(hit_data),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(mem_rdata),
        .gram_req(gram_req), .gram_we(gram_we), .gram_ok(gram_ok),
        .gram_idx(gram_addr), .gram_wdata(gram_wdata), .gram_rdata(gram_rdata),
        .dbg_req(dbg_req), .dbg_tag_sel(dbg_tag_sel), .dbg_block(dbg_block),
        .dbg_idx(dbg_addr), .dbg_info(dbg_info), .dbg_rdata(dbg_rdata)
    );

    p_rdlock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        rd_lock_q |=> rd_lock_q);

    p_ram_mode_no_burst_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && cfg_ram_mode) |=> !mem_burst);

    p_disabled_no_burst_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && !cfg_enable) |=> !mem_burst);

endmodule

// File: tb/test_lkc_top.sv
`timescale 1ns/1ps
module test_lkc_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 3;
    localparam int IW = SW + 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          cfg_enable = 1'b1, cfg_ram_mode = 1'b0, cfg_upd_lock = 1'b0, cfg_rd_lock = 1'b0;
    logic [1:0]    cfg_ram_size = 2'd0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_burst;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          gram_req = 1'b0, gram_we = 1'b0;
    logic [IW-1:0] gram_addr = '0;
    logic [DW-1:0] gram_wdata = '0, gram_rdata;
    logic          dbg_req = 1'b0, dbg_tag_sel = 1'b0;
    logic [IW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_rdata;

    lkc_top #(.ADDR_W(AW), .DATA_W(DW), .SET_W(SW)) i_lkc_top (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ram_mode(cfg_ram_mode),
        .cfg_ram_size(cfg_ram_size), .cfg_upd_lock(cfg_upd_lock), .cfg_rd_lock(cfg_rd_lock),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .gram_req(gram_req), .gram_we(gram_we), .gram_addr(gram_addr),
        .gram_wdata(gram_wdata), .gram_rdata(gram_rdata),
        .dbg_req(dbg_req), .dbg_tag_sel(dbg_tag_sel), .dbg_addr(dbg_addr),
        .dbg_rdata(dbg_rdata)
    );

    int n_chk = 0, n_bad = 0;
    int n_burst = 0, n_single = 0;
    logic resp_ready = 1'b0;
    string cur_tag = "none";
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] pend [$];
    int dly = 0;

    function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Flash model: accepts a request, answers after a short delay, one word per cycle.
    always @(negedge clk) begin
        if (dly > 0) begin
            dly--;
            mem_rvalid = 1'b0;
        end else if (pend.size() > 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = pend.pop_front();
        end else begin
            mem_rvalid = 1'b0;
        end
        if (!rst && mem_req) begin
            if (mem_burst) begin
                n_burst++;
                check(DW'(mem_addr[1:0]), '0, "R2 burst address aligned");
                for (int i = 0; i < 4; i++) pend.push_back(mval(mem_addr + AW'(i)));
            end else begin
                n_single++;
                pend.push_back(mval(mem_addr));
            end
            dly = 2;
        end
    end

    // Monitor: pops the expected word for every response.
    always @(negedge clk) begin
        if (!rst && cpu_rvalid) begin
            resp_ready = cpu_ready;
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL %s actual=%h expected=no response", cur_tag, cpu_rdata);
            end else begin
                check(cpu_rdata, exp_q.pop_front(), cur_tag);
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input int eb, input int es, input string tag);
        int b0, s0;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        b0 = n_burst; s0 = n_single;
        cur_tag = tag;
        exp_q.push_back(mval(a));
        cpu_req = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(DW'(n_burst - b0), DW'(eb), {tag, " burst count"});
        check(DW'(n_single - s0), DW'(es), {tag, " single count"});
    endtask

    task automatic dbg(input logic sel, input logic [IW-1:0] idx, input logic [DW-1:0] exp,
                       input string tag);
        @(negedge clk);
        dbg_req = 1'b1; dbg_tag_sel = sel; dbg_addr = idx;
        @(negedge clk);
        dbg_req = 1'b0;
        check(dbg_rdata, exp, tag);
    endtask

    task automatic gwr(input logic [IW-1:0] idx, input logic [DW-1:0] d);
        @(negedge clk);
        gram_req = 1'b1; gram_we = 1'b1; gram_addr = idx; gram_wdata = d;
        @(negedge clk);
        gram_req = 1'b0; gram_we = 1'b0;
    endtask

    task automatic grd(input logic [IW-1:0] idx, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        gram_req = 1'b1; gram_we = 1'b0; gram_addr = idx;
        @(negedge clk);
        gram_req = 1'b0;
        check(gram_rdata, exp, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [AW-1:0] A = 16'h0012;  // set 4, word 2, tag 0x004
    localparam logic [AW-1:0] B = 16'h0112;  // set 4, tag 0x044
    localparam logic [AW-1:0] C = 16'h0210;  // set 4, word 0
    localparam logic [AW-1:0] D = 16'h0333;  // set 4, word 3
    localparam logic [IW-1:0] I_S4W1_T = 6'd36;
    localparam logic [IW-1:0] I_S4W1_2 = 6'd38;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(DW'(cpu_ready), 1, "R11 ready after reset");
        check(DW'(cpu_rvalid), 0, "R11 no response after reset");
        check(DW'(mem_req), 0, "R11 no memory request after reset");
        dbg(1'b1, I_S4W1_T, '0, "R11 R7 tag info empty after reset");

        // R2 fill, critical word in flight, then R1 hit on same line
        rd(A, 1, 0, "R2 miss fills line");
        check(DW'(resp_ready), 0, "R2 word returned before line complete");
        rd(A + 16'd1, 0, 0, "R1 hit on filled line");
        // R3 replacement order
        rd(B, 1, 0, "R3 second tag fills other way");
        rd(A, 0, 0, "R3 first tag still resident");
        rd(C, 1, 0, "R3 third tag evicts non-MRU way");
        check(DW'(resp_ready), 0, "R2 critical word 0 early");
        rd(A, 0, 0, "R3 hit updated MRU kept A");
        rd(B, 1, 0, "R3 evicted tag misses");
        // R7 debug layout: way 1 holds A, MRU is way 0 after B fill
        dbg(1'b1, I_S4W1_T, 32'h8000_0004, "R7 tag info word");
        dbg(1'b0, I_S4W1_2, mval(A), "R7 debug data word");

        // R4 update lock
        cfg_upd_lock = 1'b1;
        rd(D, 0, 1, "R4 locked miss single read");
        rd(D, 0, 1, "R4 locked miss not filled");
        rd(A, 0, 0, "R4 hit while locked");
        cfg_upd_lock = 1'b0;

        // R5 disabled
        cfg_enable = 1'b0;
        rd(A, 0, 1, "R5 disabled forwards");
        cfg_enable = 1'b1;
        rd(A, 0, 0, "R5 tags kept while disabled");

        // R6 read lock
        @(negedge clk); cfg_rd_lock = 1'b1;
        @(negedge clk); cfg_rd_lock = 1'b0;
        dbg(1'b1, I_S4W1_T, '0, "R6 locked tag read zero");
        repeat (5) @(negedge clk);
        dbg(1'b0, I_S4W1_2, '0, "R6 lock sticky data read zero");
        rd(A, 0, 0, "R6 hits unaffected by read lock");

        // R8 R9 RAM mode
        @(negedge clk); cfg_ram_mode = 1'b1;
        grd(I_S4W1_2, '0, "R9 entering RAM mode zeroes array");
        gwr(I_S4W1_2, 32'h1234_5678);
        grd(I_S4W1_2, 32'h1234_5678, "R8 generic RAM round trip");
        dbg(1'b0, I_S4W1_2, 32'h1234_5678, "R8 read lock ignored in RAM mode");
        rd(A, 0, 1, "R8 flash bypass in RAM mode");
        cfg_upd_lock = 1'b1;
        rd(A, 0, 1, "R8 update lock ignored in RAM mode");
        cfg_upd_lock = 1'b0;
        @(negedge clk); cfg_ram_mode = 1'b0;
        rd(A, 1, 0, "R9 leaving RAM mode invalidates");

        // R10 split
        @(negedge clk); cfg_ram_size = 2'd1;
        rd(A, 1, 0, "R10 size change invalidates and refills");
        rd(A, 0, 0, "R10 hit in reduced set range");
        gwr(6'd49, 32'hCAFE_0001);
        grd(6'd49, 32'hCAFE_0001, "R10 generic set round trip");
        gwr(6'd9, 32'hDEAD_BEEF);
        grd(6'd9, '0, "R10 generic read of cache set zero");
        @(negedge clk); cfg_ram_size = 2'd3;
        grd(6'd9, '0, "R10 generic write to cache set dropped");
        grd(6'd49, 32'hCAFE_0001, "R10 generic data kept");
        rd(A, 0, 1, "R10 no cache sets bypasses");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule